// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a supervisory timer for a processor subsystem. A 24-bit counter counts down by one every fourth clock. Software must reload it in time by writing a two-byte unlock-and-feed pattern to a feed register. When the count expires, the block raises a watchdog event output, and that output stays high until reset.

The block can also reject feeds that arrive too early. A feed that completes while the count is still above a programmable ceiling is treated as a fault, and it raises the event instead of reloading the counter.

A warning interrupt gives software advance notice before expiry. It is driven by a 10-bit compare value that can only match when the counter is within the last 1024 counts. Software reaches all configuration and the live count through a simple register port, with single-cycle writes and registered reads.

Top module: `wdt_windowed`

## Requirements
- R1: After reset, the values read back are: timeout constant 0x0000FF, live count 0x0000FF, window ceiling 0xFFFFFF, warning compare 0. Both `warn_irq` and `wdt_event` are low.
- R2: The counter decrements by exactly one every 4 clock cycles. It stops at zero.
- R3: A valid feed reloads the counter from the timeout constant. The reload is visible in the count readback on the cycle after the completing write, and the warning interrupt is cleared. A valid feed is a write of 0xAA to the feed register (address 1, low 8 bits), immediately followed by a write of 0x55 to the same register.
- R4: When the first byte 0xAA is followed by any other write, the sequence aborts. This includes a different byte to the feed register or a write to another address. The counter is not reloaded, and a later lone 0x55 has no effect.
- R5: The warning compare matches only when counter bits 23:10 are all zero and counter bits 9:0 are less than or equal to the 10-bit compare value.
- R6: `warn_irq` rises on the same clock edge at which the counter takes the first value that satisfies the warning match. It then stays high until a valid feed or reset.
- R7: With a warning compare value of 0, `warn_irq` and `wdt_event` rise on the same clock edge.
- R8: `wdt_event` rises on the edge where the counter steps from 1 to 0. It stays high until reset, and later feeds do not clear it.
- R9: A feed that completes while the count is greater than the window ceiling raises `wdt_event` on that edge and does not reload the counter.
- R10: A feed that completes while the count is less than or equal to the window ceiling is accepted and reloads the counter without raising an event.
- R11: The register addresses are: 0 timeout constant, 1 feed, 2 live count (read-only), 3 warning compare, 4 window ceiling. `rdata` returns the value selected by `addr` one clock after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter advances every 4th cycle |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 24 | Write data |
| rdata | output | 24 | Registered read data |
| warn_irq | output | 1 | Warning interrupt, held until a valid feed |
| wdt_event | output | 1 | Watchdog event, held until reset |

## Verification
The feed detector is tried with three inputs: a clean 0xAA/0x55 pair, 0xAA followed by a wrong byte, and 0xAA followed by a write to another register. Together these separate a real two-step check from one that only looks at the final byte. The warning compare is driven with a reload value just above 1024 and a compare value of 1023. A compare that ignores the upper counter bits would fire at count 0x400 instead of 0x3FF. Feeds are also placed on both sides of the window ceiling, and a zero compare value is used to confirm that the warning and the event coincide.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADR_TCONST = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_FEED   = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_COUNT  = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_WARN   = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_WINDOW = 3'd4;

  typedef enum logic {FEED_IDLE, FEED_ARMED} feed_state_t;
endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst)               phase <= '0;
    else if (phase == LAST) phase <= '0;
    else                   phase <= phase + PW'(1);
  end

  assign tick = (phase == LAST);

  // R2
  tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/wdt_feed_seq.sv
module wdt_feed_seq
  import wdt_pkg::*;
#(
  parameter logic [7:0] KEY_FIRST  = 8'hAA,
  parameter logic [7:0] KEY_SECOND = 8'h55
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic       to_feed,
  input  logic [7:0] byte_in,
  output logic       feed_done
);
  feed_state_t state;

  always_ff @(posedge clk) begin
    if (rst) state <= FEED_IDLE;
    else if (wr_en) begin
      case (state)
        FEED_IDLE:  state <= (to_feed && byte_in == KEY_FIRST) ? FEED_ARMED : FEED_IDLE;
        FEED_ARMED: state <= FEED_IDLE;
        default:    state <= FEED_IDLE;
      endcase
    end
  end

  assign feed_done = wr_en && to_feed && (state == FEED_ARMED) && (byte_in == KEY_SECOND);

  // R4
  armed_leaves_chk: assert property (@(posedge clk) disable iff (rst)
    (state == FEED_ARMED && wr_en) |=> state == FEED_IDLE);
endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
  parameter int CNT_W = 24,
  parameter int WARN_W = 10,
  parameter logic [CNT_W-1:0] CNT_RST = 24'h0000FF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              feed_done,
  input  logic [CNT_W-1:0]  tconst,
  input  logic [CNT_W-1:0]  window,
  input  logic [WARN_W-1:0] warn_val,
  output logic [CNT_W-1:0]  count,
  output logic              warn_irq,
  output logic              wdt_event
);
  logic [CNT_W-1:0] next_cnt;
  logic             next_match;
  logic             too_early;

  assign next_cnt   = count - CNT_W'(1);
  assign next_match = (next_cnt[CNT_W-1:WARN_W] == '0) && (next_cnt[WARN_W-1:0] <= warn_val);
  assign too_early  = count > window;

  always_ff @(posedge clk) begin
    if (rst) begin
      count     <= CNT_RST;
      warn_irq  <= 1'b0;
      wdt_event <= 1'b0;
    end else if (feed_done) begin
      if (too_early) begin
        wdt_event <= 1'b1;
      end else begin
        count    <= tconst;
        warn_irq <= 1'b0;
      end
    end else if (tick && count != '0) begin
      count <= next_cnt;
      if (count == CNT_W'(1)) wdt_event <= 1'b1;
      if (next_match)         warn_irq  <= 1'b1;
    end
  end

  // R8
  event_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    wdt_event |=> wdt_event);
  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !feed_done && count != '0) |=> count == $past(count) - CNT_W'(1));
  // R3
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    (feed_done && count <= window) |=> (count == $past(tconst) && !warn_irq));
  // R9
  window_chk: assert property (@(posedge clk) disable iff (rst)
    (feed_done && count > window) |=> wdt_event);
  // R5
  warn_match_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(warn_irq) |-> (count[CNT_W-1:WARN_W] == '0 && count[WARN_W-1:0] <= warn_val));
endmodule

// File: rtl/wdt_windowed.sv
module wdt_windowed
  import wdt_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int WARN_W = 10,
  parameter int DIV    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic              warn_irq,
  output logic              wdt_event
);
  localparam logic [CNT_W-1:0] CNT_RST = CNT_W'(8'hFF);

  logic [CNT_W-1:0]  tconst;
  logic [CNT_W-1:0]  window;
  logic [WARN_W-1:0] warn_val;
  logic [CNT_W-1:0]  count;
  logic              tick;
  logic              feed_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      tconst   <= CNT_RST;
      window   <= '1;
      warn_val <= '0;
    end else if (wr_en) begin
      case (addr)
        ADR_TCONST: tconst   <= wdata;
        ADR_WARN:   warn_val <= wdata[WARN_W-1:0];
        ADR_WINDOW: window   <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) begin
      case (addr)
        ADR_TCONST: rdata <= tconst;
        ADR_COUNT:  rdata <= count;
        ADR_WARN:   rdata <= {{(CNT_W-WARN_W){1'b0}}, warn_val};
        ADR_WINDOW: rdata <= window;
        default:    rdata <= '0;
      endcase
    end
  end

  wdt_prescale #(.DIV(DIV)) u_presc (.clk(clk), .rst(rst), .tick(tick));

  wdt_feed_seq u_feed (
    .clk(clk), .rst(rst), .wr_en(wr_en),
    .to_feed(addr == ADR_FEED), .byte_in(wdata[7:0]),
    .feed_done(feed_done)
  );

  wdt_core #(.CNT_W(CNT_W), .WARN_W(WARN_W), .CNT_RST(CNT_RST)) u_core (
    .clk(clk), .rst(rst), .tick(tick), .feed_done(feed_done),
    .tconst(tconst), .window(window), .warn_val(warn_val),
    .count(count), .warn_irq(warn_irq), .wdt_event(wdt_event)
  );

  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

// File: tb/tb_wdt_windowed.sv
module tb_wdt_windowed;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [23:0] wdata = '0;
  logic [23:0] rdata;
  logic        warn_irq;
  logic        wdt_event;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  wdt_windowed dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .warn_irq(warn_irq), .wdt_event(wdt_event)
  );

  task automatic chk(input bit ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [23:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [23:0] v);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic feed();
    wr(3'd1, 24'hAA);
    wr(3'd1, 24'h55);
  endtask

  task automatic t_reset_state();
    logic [23:0] v;
    do_reset();
    rd(3'd0, v); chk(v == 24'hFF, "R1 tconst", v, 24'hFF);
    rd(3'd2, v); chk(v >= 24'hFD && v <= 24'hFF, "R1 count", v, 24'hFF);
    rd(3'd4, v); chk(v == 24'hFFFFFF, "R1 window", v, 24'hFFFFFF);
    rd(3'd3, v); chk(v == 24'h0, "R1 warn", v, 24'h0);
    chk(!warn_irq && !wdt_event, "R1 outputs", {22'd0, warn_irq, wdt_event}, 24'h0);
  endtask

  task automatic t_rate();
    logic [23:0] a, b;
    do_reset();
    rd(3'd2, a);
    repeat (7) @(negedge clk);
    rd(3'd2, b);
    chk(a - b == 24'd2, "R2 decrement rate", a - b, 24'd2);
  endtask

  task automatic t_feed_and_regs();
    logic [23:0] v;
    do_reset();
    wr(3'd0, 24'h000800);
    rd(3'd0, v); chk(v == 24'h800, "R11 tconst readback", v, 24'h800);
    wr(3'd4, 24'h123456);
    rd(3'd4, v); chk(v == 24'h123456, "R11 window readback", v, 24'h123456);
    wr(3'd4, 24'hFFFFFF);
    feed();
    rd(3'd2, v); chk(v == 24'h800, "R3 reload", v, 24'h800);
  endtask

  task automatic t_abort();
    logic [23:0] v;
    do_reset();
    wr(3'd0, 24'h000800);
    wr(3'd1, 24'hAA); wr(3'd1, 24'h12); wr(3'd1, 24'h55);
    rd(3'd2, v); chk(v < 24'h100, "R4 wrong byte abort", v, 24'hFF);
    wr(3'd1, 24'hAA); wr(3'd3, 24'h5); wr(3'd1, 24'h55);
    rd(3'd2, v); chk(v < 24'h100, "R4 other address abort", v, 24'hFF);
    feed();
    rd(3'd2, v); chk(v == 24'h800, "R4 clean feed after abort", v, 24'h800);
  endtask

  task automatic t_warn_upper();
    logic [23:0] v;
    int n = 0;
    do_reset();
    wr(3'd3, 24'h3FF);
    wr(3'd0, 24'h000401);
    feed();
    chk(!warn_irq, "R3 warn clear after feed", {23'd0, warn_irq}, 24'd0);
    while (!warn_irq && n < 100) begin @(negedge clk); n++; end
    rd(3'd2, v);
    chk(v == 24'h3FF, "R5 warn needs upper zero", v, 24'h3FF);
  endtask

  task automatic t_warn_edge();
    logic [23:0] v;
    int n = 0;
    do_reset();
    wr(3'd3, 24'd5);
    wr(3'd0, 24'd20);
    feed();
    while (!warn_irq && n < 200) begin @(negedge clk); n++; end
    rd(3'd2, v);
    chk(v == 24'd5, "R6 warn edge count", v, 24'd5);
    repeat (6) @(negedge clk);
    chk(warn_irq, "R6 warn held", {23'd0, warn_irq}, 24'd1);
    feed();
    chk(!warn_irq, "R3 feed clears warn", {23'd0, warn_irq}, 24'd0);
  endtask

  task automatic t_warn_zero();
    int n = 0;
    do_reset();
    wr(3'd0, 24'd3);
    feed();
    while (!warn_irq && !wdt_event && n < 100) begin @(negedge clk); n++; end
    chk(warn_irq && wdt_event, "R7 warn with event", {22'd0, warn_irq, wdt_event}, 24'd3);
  endtask

  task automatic t_expire();
    int n = 0;
    do_reset();
    chk(!wdt_event, "R8 no event early", {23'd0, wdt_event}, 24'd0);
    while (!wdt_event && n < 2000) begin @(negedge clk); n++; end
    chk(n > 1000 && n < 1030, "R8 expiry time", 24'(n), 24'd1020);
    feed();
    repeat (5) @(negedge clk);
    chk(wdt_event, "R8 event sticky", {23'd0, wdt_event}, 24'd1);
  endtask

  task automatic t_window();
    logic [23:0] v;
    int n = 0;
    do_reset();
    wr(3'd0, 24'd40);
    feed();
    wr(3'd4, 24'd20);
    v = 24'd40;
    while (v > 24'd20 && n < 200) begin rd(3'd2, v); n++; end
    feed();
    rd(3'd2, v);
    chk(v == 24'd40, "R10 feed inside window", v, 24'd40);
    chk(!wdt_event, "R10 no event", {23'd0, wdt_event}, 24'd0);
    do_reset();
    wr(3'd0, 24'd30);
    feed();
    wr(3'd4, 24'd10);
    feed();
    chk(wdt_event, "R9 early feed event", {23'd0, wdt_event}, 24'd1);
    rd(3'd2, v);
    chk(v < 24'd30, "R9 no reload", v, 24'd29);
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog timeout");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_rate();
    t_feed_and_regs();
    t_abort();
    t_warn_upper();
    t_warn_edge();
    t_warn_zero();
    t_expire();
    t_window();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule